// File: doc/BRIEF.md
# Serial EEPROM Sequential Read Responder

This block acts as the slave side of a three-wire serial EEPROM holding a fixed table of words. A host raises chip select and then clocks in one bit per serial clock edge: a start bit, a two-bit command and a word address. For a read command the block then returns the stored word one bit per edge, most significant bit first. As long as chip select stays high it moves on to the following word by itself, so one command can stream the whole table.

The serial clock is not used as a clock. It arrives as a one-cycle strobe in the system clock domain that marks each rising edge of the serial clock, together with the data-in bit sampled at that edge. The table contents are set by a parameter at elaboration time. Read is the only command. Any other command code sends the block back to waiting for a start bit.

Top module: `srom_reader`

## Requirements
- R1: After reset, `dout_o` is 0 and the block is waiting for a start bit.
- R2: While the block waits for a start bit, a strobe with `din_i`=0 leaves it waiting. The first strobe with `din_i`=1 is taken as the start bit.
- R3: After the start bit, the next two strobes carry the command code, first bit received as the MSB. Code 2'b10 selects read. Any other code (00, 01, 11) returns the block to waiting for a start bit.
- R4: After a read code, the next six strobes carry the word address, first bit received as the MSB.
- R5: On each of the following 16 strobes the block presents one data bit, from bit 15 down to bit 0 of the addressed word. The bit appears on `dout_o` in the cycle after the strobe and is held until the next strobe.
- R6: After bit 0 of a word, the address increments by one and the next strobe returns bit 15 of the next word.
- R7: Sequential reading wraps from address 63 to address 0.
- R8: When `cs_i` is low, the bit counter, command and address are cleared and the block waits for a start bit. `dout_o` is 0 from the next cycle.
- R9: `dout_o` is 0 during the start, command and address phases.
- R10: Strobes that arrive while `cs_i` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| stb_i | input | 1 | One-cycle strobe marking a rising serial clock edge |
| din_i | input | 1 | Serial data from host, valid with `stb_i` |
| dout_o | output | 1 | Serial data to host |

## Verification
Two events can fall in the same strobe: emitting bit 0 of a word and advancing the address, and at address 63 this advance also wraps to 0. The bench provokes this by starting a read at address 62 and streaming three words. Every bit is compared, so a late address increment or a missed wrap shows up as a wrong first bit of the next word. A second case drops chip select in the middle of a word. The bench then checks that the output is 0 in the next cycle and that a new command is decoded from a clean start.

// File: rtl/srom_pkg.sv
package srom_pkg;

  localparam int DEF_AW = 6;
  localparam int DEF_DW = 16;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_OP    = 2'd1,
    ST_ADDR  = 2'd2,
    ST_READ  = 2'd3
  } srom_state_e;

  // Default table: a simple address-derived pattern for the default geometry.
  function automatic logic [(1 << DEF_AW) * DEF_DW - 1:0] seed_image();
    logic [(1 << DEF_AW) * DEF_DW - 1:0] img;
    img = '0;
    for (int k = 0; k < (1 << DEF_AW); k++) begin
      img[k * DEF_DW +: DEF_DW] = DEF_DW'(16'hC3A5 ^ (k * 16'h0111));
    end
    return img;
  endfunction

endpackage

// File: rtl/srom_store.sv
module srom_store #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter logic [(1 << AW) * DW - 1:0] IMAGE = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] word_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign words[g] = IMAGE[g * DW +: DW];
  end

  assign word_o = words[addr_i];

endmodule

// File: rtl/srom_seq.sv
module srom_seq
  import srom_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int OPW = 2,
  parameter logic [OPW-1:0] READ_CODE = 2'b10,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          stb_i,
  input  logic          din_i,
  input  logic [DW-1:0] word_i,
  output logic [AW-1:0] addr_o,
  output srom_state_e   state_o,
  output logic [CW-1:0] cnt_o,
  output logic          dout_o
);

  srom_state_e    state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [OPW-1:0] op_q, op_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic           dout_q, dout_d;
  logic           upd;
  logic [CW-1:0]  bit_idx;
  logic [OPW-1:0] op_full;

  assign upd     = !cs_i || stb_i;
  assign bit_idx = cnt_q - CW'(1);
  assign op_full = {op_q[OPW-2:0], din_i};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    addr_d  = addr_q;
    dout_d  = dout_q;
    if (!cs_i) begin
      state_d = ST_START;
      cnt_d   = '0;
      op_d    = '0;
      addr_d  = '0;
      dout_d  = 1'b0;
    end else if (stb_i) begin
      unique case (state_q)
        ST_START: begin
          if (din_i) begin
            state_d = ST_OP;
            cnt_d   = '0;
          end
        end
        ST_OP: begin
          op_d  = op_full;
          cnt_d = cnt_q + CW'(1);
          if (cnt_q == CW'(OPW - 1)) begin
            cnt_d = '0;
            if (op_full == READ_CODE) begin
              state_d = ST_ADDR;
            end else begin
              state_d = ST_START;
              op_d    = '0;
            end
          end
        end
        ST_ADDR: begin
          addr_d = {addr_q[AW-2:0], din_i};
          cnt_d  = cnt_q + CW'(1);
          if (cnt_q == CW'(AW - 1)) begin
            cnt_d   = CW'(DW);
            state_d = ST_READ;
          end
        end
        ST_READ: begin
          dout_d = word_i[bit_idx];
          cnt_d  = bit_idx;
          if (cnt_q == CW'(1)) begin
            cnt_d  = CW'(DW);
            addr_d = addr_q + AW'(1);
          end
        end
        default: state_d = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      dout_q  <= 1'b0;
    end else if (upd) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      dout_q  <= dout_d;
    end
  end

  assign addr_o  = addr_q;
  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign dout_o  = dout_q;

endmodule

// File: rtl/srom_reader.sv
module srom_reader
  import srom_pkg::*;
#(
  parameter int AW = DEF_AW,
  parameter int DW = DEF_DW,
  parameter logic [(1 << AW) * DW - 1:0] IMAGE = seed_image(),
  localparam int CW = $clog2(DW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic stb_i,
  input  logic din_i,
  output logic dout_o
);

  logic [1:0]    rst_pipe;
  logic          rst_n_sync;
  logic [AW-1:0] addr_w;
  logic [DW-1:0] word_w;
  logic [CW-1:0] cnt_w;
  srom_state_e   state_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  srom_store #(.AW(AW), .DW(DW), .IMAGE(IMAGE)) u_store (
    .addr_i (addr_w),
    .word_o (word_w)
  );

  srom_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .cs_i    (cs_i),
    .stb_i   (stb_i),
    .din_i   (din_i),
    .word_i  (word_w),
    .addr_o  (addr_w),
    .state_o (state_w),
    .cnt_o   (cnt_w),
    .dout_o  (dout_o)
  );

endmodule

// File: rtl/srom_reader_chk.sv
module srom_reader_chk
  import srom_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  localparam int CW = $clog2(DW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          stb,
  input logic          din,
  input logic          dout,
  input srom_state_e   state,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] cnt
);

  AST_CS_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (dout == 1'b0 && state == ST_START && addr == '0)); // R8

  AST_START_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && stb && state == ST_START && !din) |=> state == ST_START); // R2

  AST_HEADER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_READ |-> dout == 1'b0); // R9

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !stb) |=> $stable(dout)); // R5

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && stb && state == ST_READ && cnt == CW'(1) && addr == '1) |=> addr == '0); // R7

  AST_WORD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && stb && state == ST_READ && cnt == CW'(1)) |=> cnt == CW'(DW)); // R6

endmodule

bind srom_reader srom_reader_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n_sync),
  .cs    (cs_i),
  .stb   (stb_i),
  .din   (din_i),
  .dout  (dout_o),
  .state (state_w),
  .addr  (addr_w),
  .cnt   (cnt_w)
);

// File: tb/test_srom_reader.sv
module test_srom_reader;

  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  function automatic logic [NW*DW-1:0] build_img();
    logic [NW*DW-1:0] img;
    img = '0;
    for (int k = 0; k < NW; k++) begin
      img[k*DW +: DW] = DW'(k * 40503 + 4660) ^ DW'(k << 9);
    end
    return img;
  endfunction

  localparam logic [NW*DW-1:0] IMG = build_img();

  logic clk, rst_n, cs, stb, din;
  logic dout;
  int   total, bad;
  bit   done;
  bit    q_exp[$];
  string q_tag[$];
  event  ev_chk;

  srom_reader #(.AW(AW), .DW(DW), .IMAGE(IMG)) i_srom_reader (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .stb_i(stb), .din_i(din), .dout_o(dout)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // monitor: drains the scoreboard queue at each check event
  always begin
    bit    e;
    string t;
    @(ev_chk);
    while (q_exp.size() > 0) begin
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      total++;
      if (dout !== e) begin
        bad++;
        $display("FAIL %s: dout=%0b expected %0b at %0t", t, dout, e, $time);
      end
    end
  end

  task automatic strobe(input bit d, input bit exp, input string tag);
    @(negedge clk);
    din = d; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0; din = 1'b0;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    -> ev_chk;
  endtask

  task automatic set_cs(input bit v);
    @(negedge clk); cs = v;
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a);
    strobe(1'b1, 1'b0, "R9");
    for (int i = 1; i >= 0; i--) strobe(op[i], 1'b0, "R9");
    for (int i = AW-1; i >= 0; i--) strobe(a[i], 1'b0, "R4");
  endtask

  task automatic read_words(input int a, input int n, input string tag);
    for (int w = 0; w < n; w++) begin
      for (int b = DW-1; b >= 0; b--) begin
        strobe(1'b0, IMG[((a + w) % NW)*DW + b], tag);
      end
    end
  endtask

  task automatic direct_chk(input bit exp, input string tag);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    -> ev_chk;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    cs = 0; stb = 0; din = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    direct_chk(1'b0, "R1");

    // R10: strobes with chip select low are ignored
    for (int i = 0; i < 4; i++) strobe(1'b1, 1'b0, "R10");
    set_cs(1'b1);
    send_cmd(2'b10, 6'd5);
    read_words(5, 2, "R5 R6");
    set_cs(1'b0);

    // R2: leading zeros before the start bit
    set_cs(1'b1);
    for (int i = 0; i < 3; i++) strobe(1'b0, 1'b0, "R2");
    send_cmd(2'b10, 6'h2A);
    read_words(42, 1, "R2");
    set_cs(1'b0);

    // R3: unsupported codes drop back to waiting for a start bit
    set_cs(1'b1);
    strobe(1'b1, 1'b0, "R3"); strobe(1'b1, 1'b0, "R3"); strobe(1'b1, 1'b0, "R3");
    strobe(1'b1, 1'b0, "R3"); strobe(1'b0, 1'b0, "R3"); strobe(1'b1, 1'b0, "R3");
    strobe(1'b1, 1'b0, "R3"); strobe(1'b0, 1'b0, "R3"); strobe(1'b0, 1'b0, "R3");
    send_cmd(2'b10, 6'd12);
    read_words(12, 1, "R3");
    set_cs(1'b0);

    // R7: wrap from the last word to word 0
    set_cs(1'b1);
    send_cmd(2'b10, 6'd62);
    read_words(62, 3, "R7");
    set_cs(1'b0);

    // R8: abort in mid-word, then a clean restart
    set_cs(1'b1);
    send_cmd(2'b10, 6'd9);
    for (int b = DW-1; b > DW-8; b--) strobe(1'b0, IMG[9*DW + b], "R5");
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
    direct_chk(1'b0, "R8");
    set_cs(1'b1);
    send_cmd(2'b10, 6'd9);
    read_words(9, 1, "R8");
    set_cs(1'b0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule